// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

A small fully associative table of segment entries. Each entry holds an effective-segment word and a virtual-segment descriptor word. An effective address is matched against every entry. The match takes account of segment size: a 256 MB entry compares address bits [63:28], and a 1 TB entry compares bits [63:40]. The descriptor of the matching entry is returned in the same cycle. Software-visible maintenance goes through three more paths: a checked slot write, a slot read, and two invalidation commands.

The bulk invalidation takes a 3-bit hint. The hint decides whether entry 0 is spared, whether class-0 entries are spared, or whether no entry is touched at all. The per-address invalidation removes the entry that hits and raises either a local or a global flush request for the downstream translation caches. Lookup, read and reject are combinational. All state changes land on the next rising clock edge.

Top module: `slb_array`

## Requirements
- R1: A 256 MB entry hits when its stored effective word equals {addr[63:28], 1, 27'b0} and descriptor bits [63:62] are 00. A different 256 MB segment inside the same 1 TB region misses.
- R2: A 1 TB entry hits when its stored effective word equals {addr[63:40], 12'b0, 1, 27'b0} and descriptor bits [63:62] are 01. Any offset in addr[39:0] still hits.
- R3: When several entries hit, the lowest index is reported. On a miss the hit flag is 0 and the descriptor output is all ones.
- R4: With the narrow lookup flag set, addr[63:32] is forced to zero before matching.
- R5: A write is rejected, and leaves the table unchanged, when slot (operand bits [11:0]) is not below the entry count, or when any of operand bits [26:12] is set. The stored effective word is the operand with bits [11:0] cleared, and its valid bit is bit 27.
- R6: A write is rejected when descriptor bits [63:62] are 10 or 11, when they are 01 and 1 TB support is off, or when page-size code bits [6:4] are not enabled in the PSZ_OK mask (default codes 0, 1 and 5).
- R7: The read port selects a slot with a 12-bit index and returns the effective or descriptor word. An out-of-range slot raises the bad flag and returns zero.
- R8: Bulk invalidation clears the valid bit of every entry except entry 0 and raises the local flush output in that cycle.
- R9: With v3 mode on, hint 7 clears no entry but still raises local flush.
- R10: With v3 mode on, hints 3 and 4 include entry 0. Hint 3 keeps entries whose class bit (descriptor bit 7) is 0.
- R11: With v3 mode on, hint 5 behaves as hint 0. With v3 mode off, every hint behaves as hint 0.
- R12: Per-address invalidation clears the valid bit of the hit entry. It raises local flush, or global flush when the global flag is set. A miss raises neither.
- R13: An accepted write is visible only after the next rising edge. If a write and an invalidation hit the same slot in one cycle, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_v3_i | input | 1 | Enables the extended hint decoding |
| lk_addr_i | input | 64 | Lookup effective address |
| lk_narrow_i | input | 1 | Clear upper 32 address bits before lookup |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | $clog2(N_ENTRIES) | Index of lowest hitting entry |
| lk_vsid_o | output | 64 | Descriptor of hit entry, all ones on miss |
| wr_en_i | input | 1 | Write request |
| wr_rb_i | input | 64 | Effective word with slot in bits [11:0] |
| wr_rs_i | input | 64 | Descriptor word |
| wr_reject_o | output | 1 | Write refused |
| rd_slot_i | input | 12 | Read slot |
| rd_vsid_sel_i | input | 1 | 1 selects descriptor word, 0 effective word |
| rd_data_o | output | 64 | Read data |
| rd_bad_o | output | 1 | Read slot out of range |
| ia_en_i | input | 1 | Bulk invalidation command |
| ia_hint_i | input | 3 | Bulk invalidation hint |
| ie_en_i | input | 1 | Per-address invalidation command |
| ie_addr_i | input | 64 | Address for per-address invalidation |
| ie_global_i | input | 1 | Request global instead of local flush |
| flush_local_o | output | 1 | Local flush request |
| flush_global_o | output | 1 | Global flush request |

## Verification
A slot write can fall in the same cycle as a bulk invalidation or a per-address invalidation. The bench provokes both cases. It drives a write to slot 1 together with a v3 hint-4 invalidation, then a write to slot 2 together with a per-address invalidation that hits slot 2's old segment. After the edge it reads the slots back: the written slot must hold the new valid word, and the other slots must be cleared as the hint demands. The bench also samples the lookup port while a write is pending, to confirm that the new entry appears only after the edge.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int unsigned XLEN      = 64;
  localparam int unsigned V_BIT     = 27;  // valid bit inside effective word
  localparam int unsigned SLOT_W    = 12;
  localparam int unsigned HINT_W    = 3;
  localparam int unsigned SEG_HI_W  = XLEN - 28;  // bits [63:28]
  localparam logic [1:0]  SZ_SMALL  = 2'b00;      // 256 MB
  localparam logic [1:0]  SZ_LARGE  = 2'b01;      // 1 TB
  localparam logic [2:0]  HINT_ALL  = 3'd3;
  localparam logic [2:0]  HINT_ZERO = 3'd4;
  localparam logic [2:0]  HINT_NONE = 3'd7;
  typedef logic [XLEN-1:0] word_t;
endpackage

// File: rtl/slb_match.sv
module slb_match import slb_pkg::*; #(
  parameter int unsigned N = 32
) (
  input  logic [SEG_HI_W-1:0]     addr_hi_i,
  input  logic [N-1:0][XLEN-1:0]  esid_i,
  input  logic [N-1:0][1:0]       size_i,
  output logic [N-1:0]            match_o,
  output logic                    hit_o,
  output logic [$clog2(N)-1:0]    idx_o
);
  localparam int unsigned IW = $clog2(N);

  word_t key_small, key_large;
  assign key_small = {addr_hi_i, 1'b1, 27'b0};
  assign key_large = {addr_hi_i[SEG_HI_W-1:12], 12'b0, 1'b1, 27'b0};

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = ((esid_i[g] == key_small) && (size_i[g] == SZ_SMALL)) ||
                        ((esid_i[g] == key_large) && (size_i[g] == SZ_LARGE));
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_o[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/slb_wr_check.sv
module slb_wr_check import slb_pkg::*; #(
  parameter int unsigned N      = 32,
  parameter bit          HAS_1T = 1'b1,
  parameter logic [7:0]  PSZ_OK = 8'b0010_0011
) (
  input  logic [26:0] rb_lo_i,
  input  logic [1:0]  size_i,
  input  logic [2:0]  psz_i,
  output logic        reject_o
);
  logic bad_slot, bad_resv, bad_size, bad_large, bad_psz;

  assign bad_slot  = 32'(rb_lo_i[SLOT_W-1:0]) >= N;
  assign bad_resv  = |rb_lo_i[26:SLOT_W];
  assign bad_size  = size_i[1];
  assign bad_large = (size_i == SZ_LARGE) && !HAS_1T;
  assign bad_psz   = !PSZ_OK[psz_i];
  assign reject_o  = bad_slot | bad_resv | bad_size | bad_large | bad_psz;
endmodule

// File: rtl/slb_inv_sel.sv
module slb_inv_sel import slb_pkg::*; #(
  parameter int unsigned N = 32
) (
  input  logic              en_i,
  input  logic              v3_i,
  input  logic [HINT_W-1:0] hint_i,
  input  logic [N-1:0]      cls_i,
  output logic [N-1:0]      clr_o
);
  logic skip_all, incl_zero, keep_c0;

  // undefined hint 5 and legacy hints fall through to default
  assign skip_all  = v3_i && (hint_i == HINT_NONE);
  assign incl_zero = v3_i && ((hint_i == HINT_ALL) || (hint_i == HINT_ZERO));
  assign keep_c0   = v3_i && (hint_i == HINT_ALL);

  for (genvar g = 0; g < N; g++) begin : g_sel
    if (g == 0) begin : g_first
      assign clr_o[g] = en_i && !skip_all && incl_zero && !(keep_c0 && !cls_i[g]);
    end else begin : g_rest
      assign clr_o[g] = en_i && !skip_all && !(keep_c0 && !cls_i[g]);
    end
  end
endmodule

// File: rtl/slb_array.sv
module slb_array import slb_pkg::*; #(
  parameter int unsigned N_ENTRIES = 32,
  parameter bit          HAS_1T    = 1'b1,
  parameter logic [7:0]  PSZ_OK    = 8'b0010_0011
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         mode_v3_i,
  input  logic [63:0]                  lk_addr_i,
  input  logic                         lk_narrow_i,
  output logic                         lk_hit_o,
  output logic [$clog2(N_ENTRIES)-1:0] lk_idx_o,
  output logic [63:0]                  lk_vsid_o,
  input  logic                         wr_en_i,
  input  logic [63:0]                  wr_rb_i,
  input  logic [63:0]                  wr_rs_i,
  output logic                         wr_reject_o,
  input  logic [11:0]                  rd_slot_i,
  input  logic                         rd_vsid_sel_i,
  output logic [63:0]                  rd_data_o,
  output logic                         rd_bad_o,
  input  logic                         ia_en_i,
  input  logic [2:0]                   ia_hint_i,
  input  logic                         ie_en_i,
  input  logic [63:0]                  ie_addr_i,
  input  logic                         ie_global_i,
  output logic                         flush_local_o,
  output logic                         flush_global_o
);
  localparam int unsigned IW = $clog2(N_ENTRIES);

  logic [N_ENTRIES-1:0][XLEN-1:0] esid_q, vsid_q;
  logic [N_ENTRIES-1:0][1:0]      size_arr;
  logic [N_ENTRIES-1:0]           cls_vec;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_fld
    assign size_arr[g] = vsid_q[g][63:62];
    assign cls_vec[g]  = vsid_q[g][7];
  end

  // lookup
  word_t                lk_eff;
  logic [N_ENTRIES-1:0] lk_match;
  assign lk_eff = lk_narrow_i ? {32'b0, lk_addr_i[31:0]} : lk_addr_i;

  slb_match #(.N(N_ENTRIES)) u_lk_match (
    .addr_hi_i (lk_eff[63:28]),
    .esid_i    (esid_q),
    .size_i    (size_arr),
    .match_o   (lk_match),
    .hit_o     (lk_hit_o),
    .idx_o     (lk_idx_o)
  );
  assign lk_vsid_o = lk_hit_o ? vsid_q[lk_idx_o] : '1;

  // write
  logic    wr_bad, wr_go;
  logic [IW-1:0] wr_idx;
  word_t   wr_esid;

  slb_wr_check #(.N(N_ENTRIES), .HAS_1T(HAS_1T), .PSZ_OK(PSZ_OK)) u_wr_check (
    .rb_lo_i  (wr_rb_i[26:0]),
    .size_i   (wr_rs_i[63:62]),
    .psz_i    (wr_rs_i[6:4]),
    .reject_o (wr_bad)
  );
  assign wr_reject_o = wr_en_i & wr_bad;
  assign wr_go       = wr_en_i & ~wr_bad;
  assign wr_idx      = wr_rb_i[IW-1:0];
  assign wr_esid     = {wr_rb_i[63:SLOT_W], {SLOT_W{1'b0}}};

  // read
  logic [IW-1:0] rd_idx;
  assign rd_bad_o  = 32'(rd_slot_i) >= N_ENTRIES;
  assign rd_idx    = rd_slot_i[IW-1:0];
  assign rd_data_o = rd_bad_o ? '0 : (rd_vsid_sel_i ? vsid_q[rd_idx] : esid_q[rd_idx]);

  // invalidation
  logic [N_ENTRIES-1:0] ia_clr, ie_clr, ie_match_unused;
  logic                 ie_hit;
  logic [IW-1:0]        ie_idx;

  slb_inv_sel #(.N(N_ENTRIES)) u_inv_sel (
    .en_i   (ia_en_i),
    .v3_i   (mode_v3_i),
    .hint_i (ia_hint_i),
    .cls_i  (cls_vec),
    .clr_o  (ia_clr)
  );

  slb_match #(.N(N_ENTRIES)) u_ie_match (
    .addr_hi_i (ie_addr_i[63:28]),
    .esid_i    (esid_q),
    .size_i    (size_arr),
    .match_o   (ie_match_unused),
    .hit_o     (ie_hit),
    .idx_o     (ie_idx)
  );

  always_comb begin
    ie_clr = '0;
    if (ie_en_i && ie_hit) ie_clr[ie_idx] = 1'b1;
  end

  assign flush_local_o  = ia_en_i | (ie_en_i & ie_hit & ~ie_global_i);
  assign flush_global_o = ie_en_i & ie_hit & ie_global_i;

  logic unused_bits;
  assign unused_bits = ^{lk_eff[27:0], ie_addr_i[27:0], ie_match_unused};

  // storage: write overrides a same-cycle invalidation of its slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esid_q <= '0;
      vsid_q <= '0;
    end else begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (wr_go && (wr_idx == IW'(i))) begin
          esid_q[i] <= wr_esid;
          vsid_q[i] <= wr_rs_i;
        end else if (ia_clr[i] || ie_clr[i]) begin
          esid_q[i][V_BIT] <= 1'b0;
        end
      end
    end
  end

  assert_prio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_match[lk_idx_o] &&
                  ((lk_match & ((N_ENTRIES'(1) << lk_idx_o) - N_ENTRIES'(1))) == '0)));

  assert_miss_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_match == '0));

  assert_wr_commit_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go |=> (esid_q[$past(wr_idx)] == $past(wr_esid)));

  assert_reject_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_reject_o && !ia_en_i && !ie_en_i) |=> ($stable(esid_q) && $stable(vsid_q)));

  assert_keep_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ia_en_i && !ie_en_i && !wr_en_i &&
     !(mode_v3_i && ((ia_hint_i == HINT_ALL) || (ia_hint_i == HINT_ZERO))))
    |=> (esid_q[0] == $past(esid_q[0])));

  assert_hint_none_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ia_en_i && mode_v3_i && (ia_hint_i == HINT_NONE) && !ie_en_i && !wr_en_i)
    |=> $stable(esid_q));

  assert_flush_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_en_i && !ia_en_i) |-> !(flush_local_o && flush_global_o));
endmodule

// File: tb/slb_array_tb_top.sv
`timescale 1ns/1ps
module slb_array_tb_top;
  localparam int unsigned N  = 32;
  localparam int unsigned IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          mode_v3 = 0, lk_narrow = 0, wr_en = 0, rd_sel = 0;
  logic          ia_en = 0, ie_en = 0, ie_global = 0;
  logic [63:0]   lk_addr = '0, wr_rb = '0, wr_rs = '0, ie_addr = '0;
  logic [11:0]   rd_slot = '0;
  logic [2:0]    ia_hint = '0;
  logic          lk_hit, wr_reject, rd_bad, fl_loc, fl_glb;
  logic [IW-1:0] lk_idx;
  logic [63:0]   lk_vsid, rd_data;

  slb_array #(.N_ENTRIES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_v3_i(mode_v3),
    .lk_addr_i(lk_addr), .lk_narrow_i(lk_narrow), .lk_hit_o(lk_hit),
    .lk_idx_o(lk_idx), .lk_vsid_o(lk_vsid),
    .wr_en_i(wr_en), .wr_rb_i(wr_rb), .wr_rs_i(wr_rs), .wr_reject_o(wr_reject),
    .rd_slot_i(rd_slot), .rd_vsid_sel_i(rd_sel), .rd_data_o(rd_data), .rd_bad_o(rd_bad),
    .ia_en_i(ia_en), .ia_hint_i(ia_hint), .ie_en_i(ie_en), .ie_addr_i(ie_addr),
    .ie_global_i(ie_global), .flush_local_o(fl_loc), .flush_global_o(fl_glb)
  );

  // second instance without 1 TB support, only its write check is used
  logic          n_wr_en = 0;
  logic [63:0]   n_rb = '0, n_rs = '0;
  logic          n_rej, n_hit, n_bad, n_fl, n_fg;
  logic [IW-1:0] n_idx;
  logic [63:0]   n_vsid, n_rd;
  logic          z1 = 1'b0;
  logic [63:0]   z64 = '0;
  logic [11:0]   z12 = '0;
  logic [2:0]    z3 = '0;

  slb_array #(.N_ENTRIES(N), .HAS_1T(1'b0)) dut_n (
    .clk_i(clk), .rst_ni(rst_n), .mode_v3_i(z1),
    .lk_addr_i(z64), .lk_narrow_i(z1), .lk_hit_o(n_hit),
    .lk_idx_o(n_idx), .lk_vsid_o(n_vsid),
    .wr_en_i(n_wr_en), .wr_rb_i(n_rb), .wr_rs_i(n_rs), .wr_reject_o(n_rej),
    .rd_slot_i(z12), .rd_vsid_sel_i(z1), .rd_data_o(n_rd), .rd_bad_o(n_bad),
    .ia_en_i(z1), .ia_hint_i(z3), .ie_en_i(z1), .ie_addr_i(z64),
    .ie_global_i(z1), .flush_local_o(n_fl), .flush_global_o(n_fg)
  );

  int total = 0;
  int bad   = 0;
  localparam logic [63:0] VB = 64'h0000_0000_0800_0000;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rb_s(input logic [63:0] a, input logic [11:0] slot);
    return {a[63:28], 1'b1, 15'b0, slot};
  endfunction
  function automatic logic [63:0] rb_l(input logic [63:0] a, input logic [11:0] slot);
    return {a[63:40], 12'b0, 1'b1, 15'b0, slot};
  endfunction
  function automatic logic [63:0] stored(input logic [63:0] rb);
    return {rb[63:12], 12'b0};
  endfunction

  task automatic wr(input logic [63:0] rb, input logic [63:0] rs, input bit exp_rej, input string req);
    @(negedge clk);
    wr_en = 1; wr_rb = rb; wr_rs = rs;
    #1 chk(wr_reject == exp_rej, req, 64'(wr_reject), 64'(exp_rej));
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr_n(input logic [63:0] rb, input logic [63:0] rs, input bit exp_rej, input string req);
    @(negedge clk);
    n_wr_en = 1; n_rb = rb; n_rs = rs;
    #1 chk(n_rej == exp_rej, req, 64'(n_rej), 64'(exp_rej));
    @(negedge clk);
    n_wr_en = 0;
  endtask

  task automatic look(input logic [63:0] a, input bit narrow, input bit exp_hit,
                      input int exp_idx, input logic [63:0] exp_vsid, input string req);
    @(negedge clk);
    lk_addr = a; lk_narrow = narrow;
    #1;
    chk(lk_hit == exp_hit, req, 64'(lk_hit), 64'(exp_hit));
    if (exp_hit) chk(lk_idx == IW'(exp_idx), req, 64'(lk_idx), 64'(exp_idx));
    chk(lk_vsid == exp_vsid, req, lk_vsid, exp_vsid);
    lk_narrow = 0;
  endtask

  task automatic rd(input logic [11:0] slot, input bit sel, input bit exp_bad,
                    input logic [63:0] exp, input string req);
    @(negedge clk);
    rd_slot = slot; rd_sel = sel;
    #1;
    chk(rd_bad == exp_bad, req, 64'(rd_bad), 64'(exp_bad));
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic inv_all(input bit v3, input logic [2:0] hint, input string req);
    @(negedge clk);
    ia_en = 1; mode_v3 = v3; ia_hint = hint;
    #1;
    chk(fl_loc == 1'b1, req, 64'(fl_loc), 64'd1);
    chk(fl_glb == 1'b0, req, 64'(fl_glb), 64'd0);
    @(negedge clk);
    ia_en = 0; mode_v3 = 0;
  endtask

  task automatic inv_ea(input logic [63:0] a, input bit glb, input bit exp_l,
                        input bit exp_g, input string req);
    @(negedge clk);
    ie_en = 1; ie_addr = a; ie_global = glb;
    #1;
    chk(fl_loc == exp_l, req, 64'(fl_loc), 64'(exp_l));
    chk(fl_glb == exp_g, req, 64'(fl_glb), 64'(exp_g));
    @(negedge clk);
    ie_en = 0; ie_global = 0;
  endtask

  // three-entry group for the hint scenarios
  localparam logic [63:0] KBASE = 64'h0000_0070_0000_0000;
  localparam logic [63:0] VBASE = 64'h0000_0000_00C0_0000;
  function automatic logic [63:0] k_of(input int k);
    return KBASE + (64'(k) << 28);
  endfunction

  task automatic fill3(input bit c0, input bit c1, input bit c2);
    wr(rb_s(k_of(0), 12'd0), VBASE | (c0 ? 64'h80 : 64'h0), 0, "R13 fill");
    wr(rb_s(k_of(1), 12'd1), VBASE | (c1 ? 64'h80 : 64'h0), 0, "R13 fill");
    wr(rb_s(k_of(2), 12'd2), VBASE | (c2 ? 64'h80 : 64'h0), 0, "R13 fill");
  endtask

  task automatic expect3(input bit v0, input bit v1, input bit v2, input string req);
    rd(12'd0, 0, 0, stored(rb_s(k_of(0), 12'd0)) & (v0 ? '1 : ~VB), req);
    rd(12'd1, 0, 0, stored(rb_s(k_of(1), 12'd1)) & (v1 ? '1 : ~VB), req);
    rd(12'd2, 0, 0, stored(rb_s(k_of(2), 12'd2)) & (v2 ? '1 : ~VB), req);
  endtask

  localparam logic [63:0] A  = 64'h0000_0012_3000_0000;
  localparam logic [63:0] VA = 64'h0000_0001_2345_6000;
  localparam logic [63:0] L  = 64'h0000_1200_0000_0000;
  localparam logic [63:0] VL = 64'h4000_0000_0777_0000;

  task automatic t_reset;
    look(64'h0, 0, 0, 0, '1, "R3 reset miss");
    rd(12'd0, 0, 0, 64'h0, "R7 reset read");
  endtask

  task automatic t_small;
    wr(rb_s(A, 12'd3), VA, 0, "R1 write");
    look(A | 64'h0FFF_FFF8, 0, 1, 3, VA, "R1 hit");
    look(A + 64'h1000_0000, 0, 0, 0, '1, "R1 next segment miss");
    look(64'h0000_0012_4000_0000, 0, 0, 0, '1, "R1 same 1TB region miss");
  endtask

  task automatic t_large;
    wr(rb_l(L, 12'd5), VL, 0, "R2 write");
    look(L | 64'h00FF_1234_5678, 0, 1, 5, VL, "R2 hit");
    look(L + 64'h0100_0000_0000, 0, 0, 0, '1, "R2 next region miss");
  endtask

  task automatic t_timing;
    logic [63:0] d;
    d = 64'h0000_0021_0000_0000;
    @(negedge clk);
    wr_en = 1; wr_rb = rb_s(d, 12'd4); wr_rs = 64'h0000_0000_0004_4000; lk_addr = d;
    #1 chk(lk_hit == 1'b0, "R13 not before edge", 64'(lk_hit), 64'd0);
    @(negedge clk);
    wr_en = 0;
    #1 chk(lk_hit && lk_idx == IW'(4), "R13 after edge", 64'(lk_idx), 64'd4);
  endtask

  task automatic t_prio;
    logic [63:0] c;
    c = 64'h0000_0033_7000_0000;
    wr(rb_s(c, 12'd9), 64'h0000_0000_0009_9000, 0, "R3 write hi");
    wr(rb_s(c, 12'd7), 64'h0000_0000_0007_7000, 0, "R3 write lo");
    look(c, 0, 1, 7, 64'h0000_0000_0007_7000, "R3 lowest wins");
  endtask

  task automatic t_narrow;
    wr(rb_s(64'h0000_0000_5000_0000, 12'd11), 64'h0000_0000_0011_1000, 0, "R4 write");
    look(64'hFFFF_FFFF_5000_0010, 1, 1, 11, 64'h0000_0000_0011_1000, "R4 narrow hit");
    look(64'hFFFF_FFFF_5000_0010, 0, 0, 0, '1, "R4 wide miss");
  endtask

  task automatic t_reject;
    logic [63:0] g;
    g = 64'h0000_0044_0000_0000;
    wr(rb_s(g, 12'h020), 64'h0, 1, "R5 slot range");
    look(g, 0, 0, 0, '1, "R5 no store");
    wr(rb_s(g, 12'd12) | 64'h1000, 64'h0, 1, "R5 reserved bit");
    rd(12'd12, 0, 0, 64'h0, "R5 slot untouched");
    wr(rb_s(g, 12'd12), 64'h8000_0000_0000_0000, 1, "R6 size 10");
    wr(rb_s(g, 12'd12), 64'h0000_0000_0000_0020, 1, "R6 psz code 2");
    wr(rb_s(g, 12'd12), 64'h0000_0000_0000_0050, 0, "R6 psz code 5");
    rd(12'd12, 1, 0, 64'h0000_0000_0000_0050, "R6 accepted stored");
    wr_n(rb_l(L, 12'd1), VL, 1, "R6 1TB unsupported");
    wr_n(rb_s(A, 12'd1), VA, 0, "R6 256MB on reduced");
  endtask

  task automatic t_read;
    rd(12'd3, 0, 0, stored(rb_s(A, 12'd3)), "R7 esid word");
    rd(12'd3, 1, 0, VA, "R7 vsid word");
    rd(12'd32, 0, 1, 64'h0, "R7 slot 32 bad");
    rd(12'hFFF, 1, 1, 64'h0, "R7 slot max bad");
  endtask

  task automatic t_inv_ea;
    inv_ea(L | 64'h5_0000_0000, 0, 1, 0, "R12 local");
    look(L, 0, 0, 0, '1, "R12 cleared");
    inv_ea(A, 1, 0, 1, "R12 global");
    rd(12'd3, 0, 0, stored(rb_s(A, 12'd3)) & ~VB, "R12 valid dropped");
    inv_ea(A, 1, 0, 0, "R12 miss no flush");
  endtask

  task automatic t_inv_all;
    fill3(1, 0, 1);
    inv_all(0, 3'd3, "R8 legacy");
    expect3(1, 0, 0, "R8 entry0 kept");
    look(64'hFFFF_FFFF_5000_0010, 1, 0, 0, '1, "R11 legacy ignores hint");
    fill3(1, 0, 1);
    inv_all(1, 3'd7, "R9 hint7");
    expect3(1, 1, 1, "R9 nothing cleared");
    fill3(1, 0, 1);
    inv_all(1, 3'd3, "R10 hint3");
    expect3(0, 1, 0, "R10 class0 kept");
    fill3(1, 0, 1);
    inv_all(1, 3'd4, "R10 hint4");
    expect3(0, 0, 0, "R10 all cleared");
    fill3(1, 0, 1);
    inv_all(1, 3'd5, "R11 hint5");
    expect3(1, 0, 0, "R11 as hint0");
  endtask

  task automatic t_same;
    logic [63:0] n;
    n = 64'h0000_0099_0000_0000;
    fill3(1, 1, 1);
    @(negedge clk);
    ia_en = 1; mode_v3 = 1; ia_hint = 3'd4;
    wr_en = 1; wr_rb = rb_s(n, 12'd1); wr_rs = VBASE;
    @(negedge clk);
    ia_en = 0; mode_v3 = 0; wr_en = 0;
    rd(12'd1, 0, 0, stored(rb_s(n, 12'd1)), "R13 write beats bulk");
    rd(12'd0, 0, 0, stored(rb_s(k_of(0), 12'd0)) & ~VB, "R13 bulk still applies");
    wr(rb_s(k_of(2), 12'd2), VBASE, 0, "R13 refill");
    @(negedge clk);
    ie_en = 1; ie_addr = k_of(2);
    wr_en = 1; wr_rb = rb_s(n + 64'h1000_0000, 12'd2); wr_rs = VBASE;
    @(negedge clk);
    ie_en = 0; wr_en = 0;
    rd(12'd2, 0, 0, stored(rb_s(n + 64'h1000_0000, 12'd2)), "R13 write beats per-address");
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_small;
    t_large;
    t_timing;
    t_prio;
    t_narrow;
    t_reject;
    t_read;
    t_inv_ea;
    t_inv_all;
    t_same;
    finish_run;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    finish_run;
  end
endmodule